// File: doc/BRIEF.md
# Byte-Wide Execute Unit with Condition Flags

This block executes one instruction at a time from a small set of 16-bit opcodes for a compact 8-bit processor. It holds thirty-two 8-bit working registers and an 8-bit condition register. When an opcode arrives with its valid strobe, the block decodes it, reads its operands from the registers, writes the result back and updates the condition flags as that instruction defines. A done pulse marks each completion. The 16-bit pair increment takes one cycle more than the other operations, so its completion can be seen.

The supported operations are add, add with carry, bitwise AND of two registers, AND with an 8-bit constant, arithmetic shift right, a 6-bit constant added to a register pair, clearing a single condition bit, and copying the transfer flag into a register bit. A preload port lets the surrounding logic write any working register or the whole condition register. A read port shows any working register without delay.

Top module: `byte_alu_core`

## Requirements
- R1: After reset every working register reads 0x00, `status` is 0x00 and `done` is low.
- R2: Opcode 0000_11rd_dddd_rrrr (add) and 0001_11rd_dddd_rrrr (add with carry) write Rd + Rr (+ C for the second) into Rd. d = opcode[8:4] and r = {opcode[9], opcode[3:0]}.
- R3: The condition register is I=bit7, T=bit6, H=bit5, S=bit4, V=bit3, N=bit2, Z=bit1, C=bit0. After an add, H is the carry out of bit 3, C is the carry out of bit 7, V is signed overflow, N is result bit 7 and Z is set when the result is zero. I and T are unchanged.
- R4: After every flag-changing arithmetic or logic operation, S equals N xor V.
- R5: Opcode 0010_00rd_dddd_rrrr writes Rd AND Rr. Opcode 0111_KKKK_dddd_KKKK writes R(16+dddd) AND K, where K = {opcode[11:8], opcode[3:0]}. Both clear V, set N and Z from the result, and leave C and H unchanged.
- R6: Opcode 1001_010d_dddd_0101 shifts Rd right by one and keeps bit 7. The old bit 0 goes to C, N and Z follow the result, and V = N xor C. H is unchanged.
- R7: Opcode 1001_0110_KKdd_KKKK adds K = {opcode[7:6], opcode[3:0]} to the pair R(25+2dd):R(24+2dd). N, Z, C and V follow the 16-bit result, where C is the unsigned carry and V is the signed overflow. H, T and I are unchanged.
- R8: Opcode 1001_0100_1sss_1000 clears condition bit sss and leaves every other bit and every register as it was.
- R9: Opcode 1111_100d_dddd_0bbb writes T into bit bbb of Rd, leaves the other bits of Rd as they were, and changes no flag.
- R10: `done` is high for exactly one cycle. For single-cycle operations it is high in the cycle after `opValid` is accepted. For the pair add it is high one cycle later than that, and the result is visible in that same cycle.
- R11: An opcode that matches none of the encodings above changes no register and no flag, and still gives one `done` pulse.
- R12: `opValid` is ignored in the second cycle of a pair add: that opcode does not execute and adds no `done` pulse.
- R13: A preload write (`hostRegWe` or `hostSregWe`) appears on `rdData` or `status` in the cycle after the write edge. `rdData` shows the register selected by `rdAddr` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Opcode strobe |
| opcode | input | 16 | Instruction word |
| done | output | 1 | Completion pulse |
| hostRegWe | input | 1 | Preload write enable for a working register |
| hostRegAddr | input | 5 | Preload register index |
| hostRegData | input | 8 | Preload register value |
| hostSregWe | input | 1 | Preload write enable for the condition register |
| hostSregData | input | 8 | Preload condition value |
| rdAddr | input | 5 | Read-port register index |
| rdData | output | 8 | Read-port register value |
| status | output | 8 | Condition register |

## Verification
The adders are tried with operand pairs at the edges: a low-nibble rollover separates H from C, 0x7F+1 separates V from C, 0xFF+1 produces Z together with C, and add with carry is tried with C both set and clear. The logic and shift operations start from preloaded flags, so that a C or H that should be kept can be told apart from one that was wrongly rewritten. The pair add is tried on several pairs with carries out of the low byte and out of the whole pair, and once with a second opcode held on the strobe during its second cycle. Random mixes of all encodings, random opcode words included, are compared with a bench model, and a final sweep of all registers catches writes to the wrong register.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int OPC_W = 16;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_ADC, OP_AND, OP_ANDI, OP_ASR, OP_ADIW, OP_BCLR, OP_BLD
  } opKind_e;

  typedef struct packed {
    logic    fire;
    logic    wordHi;
    opKind_e kind;
  } aluCtl_t;

  function automatic opKind_e decodeOp(input logic [OPC_W-1:0] op);
    opKind_e k;
    k = OP_NONE;
    if (op[15:10] == 6'b000011) k = OP_ADD;
    else if (op[15:10] == 6'b000111) k = OP_ADC;
    else if (op[15:10] == 6'b001000) k = OP_AND;
    else if (op[15:12] == 4'b0111) k = OP_ANDI;
    else if (op[15:8] == 8'h96) k = OP_ADIW;
    else if (op[15:9] == 7'b1001010 && op[3:0] == 4'b0101) k = OP_ASR;
    else if (op[15:7] == 9'b100101001 && op[3:0] == 4'b1000) k = OP_BCLR;
    else if (op[15:9] == 7'b1111100 && !op[3]) k = OP_BLD;
    return k;
  endfunction
endpackage

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OPC_W-1:0] opcode,
  output aluCtl_t          ctl,
  output logic             busy,
  output logic             done
);
  logic hiPending;

  assign busy = hiPending;

  always_comb begin
    ctl.fire   = opValid && !hiPending;
    ctl.wordHi = hiPending;
    ctl.kind   = decodeOp(opcode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiPending <= 1'b0;
      done      <= 1'b0;
    end else begin
      hiPending <= ctl.fire && (ctl.kind == OP_ADIW);
      done      <= (ctl.fire && (ctl.kind != OP_ADIW)) || hiPending;
    end
  end
endmodule

// File: rtl/byte_alu_dp.sv
module byte_alu_dp
  import byte_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 32,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtl_t           ctl,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              hostRegWe,
  input  logic [ADDR_W-1:0] hostRegAddr,
  input  logic [DATA_W-1:0] hostRegData,
  input  logic              hostSregWe,
  input  logic [7:0]        hostSregData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        sreg
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] rf [REG_CNT];
  logic [ADDR_W-1:0] dIdx, rIdx, immIdx, pairLo, aIdx, wrIdx, hiIdxQ;
  logic [DATA_W-1:0] imm8, opA, opB, res, wrVal;
  logic [5:0]        imm6;
  logic [DATA_W:0]   sum9;
  logic [4:0]        nib;
  logic              cin, nF, vF, zF, cF, wrEn, sregUpd, saveAdiw;
  logic              carryQ, loZeroQ;
  logic [7:0]        sregNext;

  assign dIdx   = opcode[8:4];
  assign rIdx   = {opcode[9], opcode[3:0]};
  assign immIdx = {1'b1, opcode[7:4]};
  assign pairLo = {2'b11, opcode[5:4], 1'b0};
  assign imm8   = {opcode[11:8], opcode[3:0]};
  assign imm6   = {opcode[7:6], opcode[3:0]};
  assign rdData = rf[rdAddr];

  function automatic logic [7:0] putNvz(input logic [7:0] s, input logic n, input logic v,
                                        input logic z);
    logic [7:0] t;
    t = s;
    t[FL_N] = n;
    t[FL_V] = v;
    t[FL_Z] = z;
    t[FL_S] = n ^ v;
    return t;
  endfunction

  always_comb begin
    if (ctl.wordHi) aIdx = hiIdxQ;
    else if (ctl.kind == OP_ANDI) aIdx = immIdx;
    else if (ctl.kind == OP_ADIW) aIdx = pairLo;
    else aIdx = dIdx;
    opA      = rf[aIdx];
    opB      = rf[rIdx];
    cin      = 1'b0;
    sum9     = '0;
    nib      = '0;
    res      = '0;
    nF       = 1'b0;
    vF       = 1'b0;
    zF       = 1'b0;
    cF       = 1'b0;
    wrEn     = 1'b0;
    wrIdx    = aIdx;
    wrVal    = '0;
    sregNext = sreg;
    sregUpd  = 1'b0;
    saveAdiw = 1'b0;
    if (ctl.wordHi) begin
      sum9     = {1'b0, opA} + (DATA_W+1)'(carryQ);
      res      = sum9[MSB:0];
      nF       = res[MSB];
      vF       = !opA[MSB] && nF;
      cF       = opA[MSB] && !nF;
      zF       = loZeroQ && (res == '0);
      wrEn     = 1'b1;
      wrVal    = res;
      sregNext = putNvz(sreg, nF, vF, zF);
      sregNext[FL_C] = cF;
      sregUpd  = 1'b1;
    end else if (ctl.fire) begin
      case (ctl.kind)
        OP_ADD, OP_ADC: begin
          cin      = (ctl.kind == OP_ADC) && sreg[FL_C];
          sum9     = {1'b0, opA} + {1'b0, opB} + (DATA_W+1)'(cin);
          nib      = {1'b0, opA[3:0]} + {1'b0, opB[3:0]} + 5'(cin);
          res      = sum9[MSB:0];
          nF       = res[MSB];
          vF       = (opA[MSB] == opB[MSB]) && (res[MSB] != opA[MSB]);
          wrEn     = 1'b1;
          wrVal    = res;
          sregNext = putNvz(sreg, nF, vF, res == '0);
          sregNext[FL_C] = sum9[DATA_W];
          sregNext[FL_H] = nib[4];
          sregUpd  = 1'b1;
        end
        OP_AND, OP_ANDI: begin
          res      = opA & ((ctl.kind == OP_AND) ? opB : imm8);
          wrEn     = 1'b1;
          wrVal    = res;
          sregNext = putNvz(sreg, res[MSB], 1'b0, res == '0);
          sregUpd  = 1'b1;
        end
        OP_ASR: begin
          res      = {opA[MSB], opA[MSB:1]};
          cF       = opA[0];
          nF       = res[MSB];
          wrEn     = 1'b1;
          wrVal    = res;
          sregNext = putNvz(sreg, nF, nF ^ cF, res == '0);
          sregNext[FL_C] = cF;
          sregUpd  = 1'b1;
        end
        OP_ADIW: begin
          sum9     = {1'b0, opA} + (DATA_W+1)'(imm6);
          wrEn     = 1'b1;
          wrVal    = sum9[MSB:0];
          saveAdiw = 1'b1;
        end
        OP_BCLR: begin
          sregNext[opcode[6:4]] = 1'b0;
          sregUpd  = 1'b1;
        end
        OP_BLD: begin
          res      = opA;
          res[opcode[2:0]] = sreg[FL_T];
          wrEn     = 1'b1;
          wrVal    = res;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) rf[i] <= '0;
      sreg    <= '0;
      carryQ  <= 1'b0;
      loZeroQ <= 1'b0;
      hiIdxQ  <= '0;
    end else begin
      if (hostRegWe) rf[hostRegAddr] <= hostRegData;
      if (wrEn) rf[wrIdx] <= wrVal;
      if (hostSregWe) sreg <= hostSregData;
      if (sregUpd) sreg <= sregNext;
      if (saveAdiw) begin
        carryQ  <= sum9[DATA_W];
        loZeroQ <= (sum9[MSB:0] == '0);
        hiIdxQ  <= {pairLo[ADDR_W-1:1], 1'b1};
      end
    end
  end
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
  import byte_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 32,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [15:0]       opcode,
  output logic              done,
  input  logic              hostRegWe,
  input  logic [ADDR_W-1:0] hostRegAddr,
  input  logic [DATA_W-1:0] hostRegData,
  input  logic              hostSregWe,
  input  logic [7:0]        hostSregData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        status
);
  aluCtl_t ctl;
  logic    busy;

  byte_alu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .ctl(ctl), .busy(busy), .done(done)
  );

  byte_alu_dp #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opcode(opcode),
    .hostRegWe(hostRegWe), .hostRegAddr(hostRegAddr), .hostRegData(hostRegData),
    .hostSregWe(hostSregWe), .hostSregData(hostSregData),
    .rdAddr(rdAddr), .rdData(rdData), .sreg(status)
  );
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [15:0] opcode,
  input logic        done,
  input logic        busy,
  input logic        hostSregWe,
  input logic [7:0]  status
);
  logic accept, isWord, isBld, isLogic, isArith;
  assign accept  = opValid && !busy;
  assign isWord  = (opcode[15:8] == 8'h96);
  assign isBld   = (opcode[15:9] == 7'b1111100) && !opcode[3];
  assign isLogic = (opcode[15:10] == 6'b001000) || (opcode[15:12] == 4'b0111);
  assign isArith = isLogic || (opcode[15:10] == 6'b000011) || (opcode[15:10] == 6'b000111)
                   || ((opcode[15:9] == 7'b1001010) && (opcode[3:0] == 4'b0101));

  p_single_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    accept && !isWord |=> done);
  p_word_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    accept && isWord |=> !done ##1 done);
  p_second_phase_r12: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> done && !busy);
  p_bld_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    accept && isBld && !hostSregWe |=> $stable(status));
  p_logic_v_r5: assert property (@(posedge clk) disable iff (!rstN)
    accept && isLogic && !hostSregWe |=> !status[3]);
  p_sign_rule_r4: assert property (@(posedge clk) disable iff (!rstN)
    accept && isArith && !hostSregWe |=> status[4] == (status[2] ^ status[3]));
endmodule

bind byte_alu_core byte_alu_chk u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode), .done(done),
  .busy(busy), .hostSregWe(hostSregWe), .status(status)
);

// File: tb/byte_alu_core_bench.sv
`timescale 1ns/1ps
module byte_alu_core_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [15:0] opcode = '0;
  logic        done;
  logic        hostRegWe = 1'b0;
  logic [4:0]  hostRegAddr = '0;
  logic [7:0]  hostRegData = '0;
  logic        hostSregWe = 1'b0;
  logic [7:0]  hostSregData = '0;
  logic [4:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic [7:0]  status;

  int checks = 0;
  int failures = 0;
  logic [7:0] mReg [32];
  logic [7:0] mSr;
  int nDst;
  logic [4:0] dst0, dst1;

  always #2 clk = ~clk;

  byte_alu_core u_byte_alu_core (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode), .done(done),
    .hostRegWe(hostRegWe), .hostRegAddr(hostRegAddr), .hostRegData(hostRegData),
    .hostSregWe(hostSregWe), .hostSregData(hostSregData),
    .rdAddr(rdAddr), .rdData(rdData), .status(status)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [4:0] idx, output logic [7:0] v);
    rdAddr = idx;
    #0.1;
    v = rdData;
  endtask

  task automatic hostReg(input logic [4:0] idx, input logic [7:0] val);
    @(negedge clk);
    hostRegWe = 1'b1; hostRegAddr = idx; hostRegData = val;
    @(negedge clk);
    hostRegWe = 1'b0;
    mReg[idx] = val;
  endtask

  task automatic hostSr(input logic [7:0] val);
    @(negedge clk);
    hostSregWe = 1'b1; hostSregData = val;
    @(negedge clk);
    hostSregWe = 1'b0;
    mSr = val;
  endtask

  function automatic int sx(input logic [7:0] v);
    return v > 127 ? int'(v) - 256 : int'(v);
  endfunction

  function automatic logic [7:0] flagsNvz(input logic [7:0] s, input bit n, input bit v, input bit z);
    logic [7:0] t;
    t = s;
    t[2] = n; t[3] = v; t[1] = z; t[4] = n ^ v;
    return t;
  endfunction

  // Independent reference for every encoding listed in the requirements.
  task automatic modelOp(input logic [15:0] op);
    int a, b, ci, u, sv, w;
    logic [7:0] res;
    logic [4:0] d;
    nDst = 0;
    d = op[8:4];
    if (op[15:10] == 6'b000011 || op[15:10] == 6'b000111) begin
      a = mReg[d]; b = mReg[{op[9], op[3:0]}];
      ci = op[12] ? int'(mSr[0]) : 0;
      u = a + b + ci; res = u[7:0];
      sv = sx(a) + sx(b) + ci;
      mSr = flagsNvz(mSr, res[7], (sv > 127) || (sv < -128), res == 0);
      mSr[0] = u > 255;
      mSr[5] = ((a % 16) + (b % 16) + ci) > 15;
      mReg[d] = res; nDst = 1; dst0 = d;
    end else if (op[15:10] == 6'b001000) begin
      res = mReg[d] & mReg[{op[9], op[3:0]}];
      mSr = flagsNvz(mSr, res[7], 1'b0, res == 0);
      mReg[d] = res; nDst = 1; dst0 = d;
    end else if (op[15:12] == 4'b0111) begin
      d = 5'd16 + 5'(op[7:4]);
      res = mReg[d] & {op[11:8], op[3:0]};
      mSr = flagsNvz(mSr, res[7], 1'b0, res == 0);
      mReg[d] = res; nDst = 1; dst0 = d;
    end else if (op[15:8] == 8'h96) begin
      dst0 = 5'd24 + 5'(2 * op[5:4]); dst1 = dst0 + 5'd1;
      w = int'({mReg[dst1], mReg[dst0]}) + int'({op[7:6], op[3:0]});
      sv = (w > 65535) ? w - 65536 : w;
      mSr = flagsNvz(mSr, sv[15], (mReg[dst1] < 128) && (sv >= 32768), sv[15:0] == 0);
      mSr[0] = w > 65535;
      mReg[dst0] = sv[7:0]; mReg[dst1] = sv[15:8]; nDst = 2;
    end else if (op[15:9] == 7'b1001010 && op[3:0] == 4'b0101) begin
      a = mReg[d];
      res = 8'(sx(a) >>> 1);
      mSr = flagsNvz(mSr, res[7], res[7] ^ a[0], res == 0);
      mSr[0] = a[0];
      mReg[d] = res; nDst = 1; dst0 = d;
    end else if (op[15:7] == 9'b100101001 && op[3:0] == 4'b1000) begin
      mSr[op[6:4]] = 1'b0;
    end else if (op[15:9] == 7'b1111100 && !op[3]) begin
      mReg[d][op[2:0]] = mSr[6]; nDst = 1; dst0 = d;
    end
  endtask

  function automatic string tagFor(input logic [15:0] op);
    if (op[15:11] == 5'b00001 || op[15:11] == 5'b00011) return "R2/R3";
    if (op[15:10] == 6'b001000 || op[15:12] == 4'b0111) return "R5";
    if (op[15:8] == 8'h96) return "R7";
    if (op[15:9] == 7'b1001010 && op[3:0] == 4'b0101) return "R6";
    if (op[15:7] == 9'b100101001 && op[3:0] == 4'b1000) return "R8";
    if (op[15:9] == 7'b1111100 && !op[3]) return "R9";
    return "R11";
  endfunction

  task automatic runOp(input logic [15:0] op);
    logic [7:0] v;
    string tg;
    tg = tagFor(op);
    @(negedge clk);
    opValid = 1'b1; opcode = op;
    @(negedge clk);
    opValid = 1'b0;
    if (op[15:8] == 8'h96) begin
      check(done == 1'b0, "R10 pair add early done", done, 0);
      @(negedge clk);
    end
    check(done == 1'b1, "R10 done pulse", done, 1);
    modelOp(op);
    check(status == mSr, {tg, " R4 status"}, status, mSr);
    if (nDst > 0) begin
      readReg(dst0, v);
      check(v == mReg[dst0], {tg, " result"}, v, mReg[dst0]);
    end
    if (nDst > 1) begin
      readReg(dst1, v);
      check(v == mReg[dst1], {tg, " high byte"}, v, mReg[dst1]);
    end
    @(negedge clk);
    check(done == 1'b0, "R10 single pulse", done, 0);
  endtask

  task automatic sweep(input string tg);
    logic [7:0] v;
    for (int i = 0; i < 32; i++) begin
      readReg(5'(i), v);
      check(v == mReg[i], tg, v, mReg[i]);
    end
  endtask

  function automatic logic [15:0] encAdd(input logic [4:0] d, input logic [4:0] r, input bit c);
    return {3'b000, c, 2'b11, r[4], d, r[3:0]};
  endfunction
  function automatic logic [15:0] encAnd(input logic [4:0] d, input logic [4:0] r);
    return {6'b001000, r[4], d, r[3:0]};
  endfunction
  function automatic logic [15:0] encAndi(input logic [3:0] d, input logic [7:0] k);
    return {4'b0111, k[7:4], d, k[3:0]};
  endfunction
  function automatic logic [15:0] encAsr(input logic [4:0] d);
    return {7'b1001010, d, 4'b0101};
  endfunction
  function automatic logic [15:0] encAdiw(input logic [1:0] p, input logic [5:0] k);
    return {8'h96, k[5:4], p, k[3:0]};
  endfunction
  function automatic logic [15:0] encBclr(input logic [2:0] s);
    return {9'b100101001, s, 4'b1000};
  endfunction
  function automatic logic [15:0] encBld(input logic [4:0] d, input logic [2:0] b);
    return {7'b1111100, d, 1'b0, b};
  endfunction

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) mReg[i] = 8'h00;
    mSr = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done", done, 0);
    check(status == 8'h00, "R1 status", status, 0);
    sweep("R1 register reset");

    // R13: preload path
    hostReg(5'd3, 8'hA5);
    readReg(5'd3, v);
    check(v == 8'hA5, "R13 register preload", v, 8'hA5);
    hostSr(8'h81);
    check(status == 8'h81, "R13 status preload", status, 8'h81);

    // R2/R3: add corners
    hostSr(8'h00); hostReg(5'd1, 8'h0F); hostReg(5'd2, 8'h01);
    runOp(encAdd(5'd1, 5'd2, 1'b0));
    check(status == 8'h20, "R3 half carry only", status, 8'h20);
    hostSr(8'h00); hostReg(5'd4, 8'h7F); hostReg(5'd20, 8'h01);
    runOp(encAdd(5'd4, 5'd20, 1'b0));
    check(status == 8'h2C, "R3 signed overflow", status, 8'h2C);
    hostSr(8'h00); hostReg(5'd6, 8'hFF); hostReg(5'd7, 8'h01);
    runOp(encAdd(5'd6, 5'd7, 1'b0));
    check(status == 8'h23, "R3 zero with carry", status, 8'h23);
    hostSr(8'h01); hostReg(5'd8, 8'h10); hostReg(5'd9, 8'h20);
    runOp(encAdd(5'd8, 5'd9, 1'b1));
    readReg(5'd8, v);
    check(v == 8'h31, "R2 add with carry in", v, 8'h31);

    // R5: AND immediate keeps C and H
    hostSr(8'h21); hostReg(5'd16, 8'hF0);
    runOp(encAndi(4'd0, 8'h0F));
    check(status == 8'h23, "R5 C and H kept", status, 8'h23);

    // R6: arithmetic shift
    hostSr(8'h00); hostReg(5'd10, 8'h81);
    runOp(encAsr(5'd10));
    readReg(5'd10, v);
    check(v == 8'hC0, "R6 sign kept", v, 8'hC0);
    check(status == 8'h15, "R6 flags", status, 8'h15);

    // R7: pair add
    hostSr(8'h00); hostReg(5'd30, 8'hFF); hostReg(5'd31, 8'hFF);
    runOp(encAdiw(2'd3, 6'd1));
    check(status == 8'h03, "R7 pair wrap", status, 8'h03);
    hostSr(8'h00); hostReg(5'd28, 8'hFF); hostReg(5'd29, 8'h7F);
    runOp(encAdiw(2'd2, 6'd1));
    check(status == 8'h0C, "R7 pair overflow", status, 8'h0C);
    hostReg(5'd24, 8'hF0); hostReg(5'd25, 8'h12);
    runOp(encAdiw(2'd0, 6'd63));

    // R8: clear single bits
    hostSr(8'hFF);
    runOp(encBclr(3'd7));
    check(status == 8'h7F, "R8 clear top bit", status, 8'h7F);
    runOp(encBclr(3'd0));
    check(status == 8'h7E, "R8 clear carry", status, 8'h7E);

    // R9: bit load from T
    hostSr(8'h40); hostReg(5'd5, 8'h00);
    runOp(encBld(5'd5, 3'd3));
    readReg(5'd5, v);
    check(v == 8'h08, "R9 bit set from T", v, 8'h08);
    check(status == 8'h40, "R9 flags kept", status, 8'h40);

    // R11: unrecognised opcodes
    runOp(16'h0000);
    runOp(16'hFFFF);
    sweep("R11 no register change");

    // R12: strobe during second phase of a pair add is ignored
    hostReg(5'd0, 8'h01); hostReg(5'd11, 8'h02); hostReg(5'd26, 8'h10);
    @(negedge clk);
    opValid = 1'b1; opcode = encAdiw(2'd1, 6'd1);
    @(negedge clk);
    opcode = encAdd(5'd0, 5'd11, 1'b0);
    check(done == 1'b0, "R12 first cycle", done, 0);
    @(negedge clk);
    opValid = 1'b0;
    check(done == 1'b1, "R12 pair done", done, 1);
    modelOp(encAdiw(2'd1, 6'd1));
    @(negedge clk);
    check(done == 1'b0, "R12 no extra done", done, 0);
    readReg(5'd0, v);
    check(v == 8'h01, "R12 ignored add", v, 8'h01);
    readReg(5'd26, v);
    check(v == 8'h11, "R12 pair result", v, 8'h11);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] op;
      logic [4:0] d, r;
      logic [7:0] k;
      d = 5'($urandom); r = 5'($urandom); k = 8'($urandom);
      if ($urandom % 4 == 0) hostReg(5'($urandom), 8'($urandom));
      if ($urandom % 8 == 0) hostSr(8'($urandom));
      case ($urandom % 9)
        0: op = encAdd(d, r, 1'b0);
        1: op = encAdd(d, r, 1'b1);
        2: op = encAnd(d, r);
        3: op = encAndi(d[3:0], k);
        4: op = encAsr(d);
        5: op = encAdiw(d[1:0], k[5:0]);
        6: op = encBclr(d[2:0]);
        7: op = encBld(d, r[2:0]);
        default: op = 16'($urandom);
      endcase
      runOp(op);
    end
    sweep("R2 final register sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule